// File: doc/BRIEF.md
# Shared Memory Burst Command Arbiter

This block puts several independent clients in front of one word-wide memory interface. Each client has a private queue of burst commands. A command is either a read, which fetches a run of consecutive words into that client's read data queue, or a write, which sends words taken from that client's write data queue to consecutive addresses. A central arbiter picks the next command to run and sequences the whole burst on the memory side. Clients keep queueing commands and data while another client's burst is in flight.

Arbitration rotates among ports whose head command can run without stalling in the middle of a burst. A write is eligible only once its whole payload is already queued. A read is eligible only when the read data queue has room for every word it will bring back. A burst that has started always finishes before the next one begins. The memory side is a simple request/ready handshake with in-order read responses flagged by a valid strobe. `DATA_DEPTH` must be at least `2**LEN_W`.

Top module: `mparb_top`

## Requirements
- R1: Each port has its own command queue of `CMD_DEPTH` entries, with full and empty flags. It accepts commands while another port's burst is in progress.
- R2: A command push into a full queue is dropped. It sets that port's overflow flag, which stays set until reset and leaves other ports' flags alone.
- R3: A read command moves exactly the burst's word count from consecutive addresses, starting at its address, into that port's read data queue in address order.
- R4: A write command stores exactly the burst's word count, taken in queue order from that port's write data queue, at consecutive addresses starting at its address.
- R5: Only one burst runs at a time and a started burst is never interrupted. A request not yet accepted (`mem_ready` low) keeps its address and direction.
- R6: Grants rotate. After port p is granted, the search for the next eligible port starts at p+1 and wraps, and port 0 is searched first after reset.
- R7: A write command is not issued until the port's write data queue holds its full word count.
- R8: A read command is not issued unless the port's read data queue has room for its full word count.
- R9: After reset all command and read data queues are empty, no full or overflow flag is set, and no memory request is raised.
- R10: The burst length field holds the word count minus one, so the largest burst is `2**LEN_W` words (16 words, 64 bytes, at the default widths).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_push | input | NPORTS | Per-port command push strobe |
| cmd_write | input | NPORTS | Per-port command direction, 1 = write |
| cmd_addr | input | NPORTS*ADDR_W | Per-port burst start address, port i at [i*ADDR_W +: ADDR_W] |
| cmd_len | input | NPORTS*LEN_W | Per-port burst word count minus one |
| cmd_full | output | NPORTS | Command queue full |
| cmd_empty | output | NPORTS | Command queue empty |
| cmd_ovf | output | NPORTS | Sticky dropped-push flag |
| wr_push | input | NPORTS | Write data push strobe |
| wr_data | input | NPORTS*DATA_W | Write data word per port |
| wr_full | output | NPORTS | Write data queue full |
| rd_pop | input | NPORTS | Read data pop strobe |
| rd_data | output | NPORTS*DATA_W | Head word of each read data queue |
| rd_empty | output | NPORTS | Read data queue empty |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request direction, 1 = write |
| mem_addr | output | ADDR_W | Request word address |
| mem_wdata | output | DATA_W | Write word |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read response word valid, in request order |
| mem_rdata | input | DATA_W | Read response word |

## Verification
The bench builds the block with three ports, an 8-bit address, four-entry command queues and sixteen-word data queues equal to the maximum burst. With these sizes a single stalled read plus four queued commands fills a queue and reaches the overflow path. A single unread full burst is enough to block the next read for lack of room. Three ports make the wrap of the rotating grant visible, because a grant to the middle port must be followed by the last port and then the first.

// File: rtl/mparb_pkg.sv
package mparb_pkg;
  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/mparb_fifo.sv
module mparb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [WIDTH-1:0]             wdata,
  output logic [WIDTH-1:0]             rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_full, is_empty, do_push, do_pop;

  always_comb begin
    is_full  = (cnt_q == CNT_W'(DEPTH));
    is_empty = (cnt_q == '0);
    do_push  = push && !is_full;
    do_pop   = pop && !is_empty;
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wp_q] <= wdata;
  end

  assign rdata = store[rp_q];
  assign count = cnt_q;

  // R2
  fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && is_full && !pop) |=> (cnt_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/mparb_rr.sv
module mparb_rr #(
  parameter int N = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 take,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] grant_idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q, last_d;
  logic          hit;
  int            cand;

  always_comb begin
    grant     = '0;
    grant_idx = last_q;
    hit       = 1'b0;
    cand      = 0;
    for (int k = 1; k <= N; k++) begin
      cand = (int'(last_q) + k) % N;
      if (!hit && req[cand]) begin
        grant[cand] = 1'b1;
        grant_idx   = IW'(cand);
        hit         = 1'b1;
      end
    end
    last_d = (take && hit) ? grant_idx : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end

  // R6
  rr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R6
  rr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (req != '0) && !req[last_q]) |=> (last_q != $past(last_q)));
endmodule

// File: rtl/mparb_engine.sv
module mparb_engine
  import mparb_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic [PW-1:0] start_port,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [PW-1:0] port,
  output logic          wdata_pop,
  output logic          rdata_push
);
  localparam int CW = LW + 1;

  eng_state_e    state_q, state_d;
  logic          we_q, we_d;
  logic [AW-1:0] base_q, base_d;
  logic [CW-1:0] words_q, words_d, iss_q, iss_d, rsp_q, rsp_d;
  logic [PW-1:0] port_q, port_d;
  logic          accept, last_w, last_r;

  always_comb begin
    mem_req    = (state_q == ENG_RUN) && (iss_q != words_q);
    accept     = mem_req && mem_ready;
    wdata_pop  = accept && we_q;
    rdata_push = (state_q == ENG_RUN) && !we_q && mem_rvalid;
    last_w     = wdata_pop && (iss_q == words_q - 1'b1);
    last_r     = rdata_push && (rsp_q == words_q - 1'b1);

    state_d = state_q;
    we_d    = we_q;
    base_d  = base_q;
    words_d = words_q;
    iss_d   = iss_q;
    rsp_d   = rsp_q;
    port_d  = port_q;
    case (state_q)
      ENG_IDLE: begin
        if (start) begin
          state_d = ENG_RUN;
          we_d    = start_we;
          base_d  = start_addr;
          words_d = CW'(start_len) + 1'b1;
          iss_d   = '0;
          rsp_d   = '0;
          port_d  = start_port;
        end
      end
      default: begin
        if (accept)     iss_d = iss_q + 1'b1;
        if (rdata_push) rsp_d = rsp_q + 1'b1;
        if (last_w || last_r) state_d = ENG_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      we_q    <= 1'b0;
      base_q  <= '0;
      words_q <= '0;
      iss_q   <= '0;
      rsp_q   <= '0;
      port_q  <= '0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      base_q  <= base_d;
      words_q <= words_d;
      iss_q   <= iss_d;
      rsp_q   <= rsp_d;
      port_q  <= port_d;
    end
  end

  assign busy     = (state_q == ENG_RUN);
  assign mem_we   = we_q;
  assign mem_addr = base_q + AW'(iss_q);
  assign port     = port_q;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (state_q == ENG_IDLE));
  // R3
  rsp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_push |-> (rsp_q < iss_q));
endmodule

// File: rtl/mparb_top.sv
module mparb_top #(
  parameter int NPORTS     = 3,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 4,
  parameter int CMD_DEPTH  = 4,
  parameter int DATA_DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORTS-1:0]          cmd_push,
  input  logic [NPORTS-1:0]          cmd_write,
  input  logic [NPORTS*ADDR_W-1:0]   cmd_addr,
  input  logic [NPORTS*LEN_W-1:0]    cmd_len,
  output logic [NPORTS-1:0]          cmd_full,
  output logic [NPORTS-1:0]          cmd_empty,
  output logic [NPORTS-1:0]          cmd_ovf,
  input  logic [NPORTS-1:0]          wr_push,
  input  logic [NPORTS*DATA_W-1:0]   wr_data,
  output logic [NPORTS-1:0]          wr_full,
  input  logic [NPORTS-1:0]          rd_pop,
  output logic [NPORTS*DATA_W-1:0]   rd_data,
  output logic [NPORTS-1:0]          rd_empty,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic                       mem_ready,
  input  logic                       mem_rvalid,
  input  logic [DATA_W-1:0]          mem_rdata
);
  localparam int CMDW  = 1 + ADDR_W + LEN_W;
  localparam int PW    = $clog2(NPORTS);
  localparam int CCW   = $clog2(CMD_DEPTH + 1);
  localparam int DCW   = $clog2(DATA_DEPTH + 1);

  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [CMDW-1:0]   head     [NPORTS];
  logic [DATA_W-1:0] wr_head  [NPORTS];
  logic [CCW-1:0]    cmd_cnt  [NPORTS];
  logic [DCW-1:0]    wr_cnt   [NPORTS];
  logic [DCW-1:0]    rd_cnt   [NPORTS];
  logic [NPORTS-1:0] elig, cmd_pop_v, wr_pop_v, rd_push_v, rd_full_v, wr_empty_v;
  logic [NPORTS-1:0] ovf_q, ovf_d, arb_req, grant;
  logic [PW-1:0]     grant_idx, eng_port;
  logic              eng_busy, take, eng_pop, eng_push;

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic          h_we;
    logic [31:0]   need;

    mparb_fifo #(.WIDTH(CMDW), .DEPTH(CMD_DEPTH)) u_cmd (
      .clk(clk), .rst_n(rst_s), .push(cmd_push[i]), .pop(cmd_pop_v[i]),
      .wdata({cmd_write[i], cmd_addr[i*ADDR_W +: ADDR_W], cmd_len[i*LEN_W +: LEN_W]}),
      .rdata(head[i]), .count(cmd_cnt[i]));

    mparb_fifo #(.WIDTH(DATA_W), .DEPTH(DATA_DEPTH)) u_wr (
      .clk(clk), .rst_n(rst_s), .push(wr_push[i]), .pop(wr_pop_v[i]),
      .wdata(wr_data[i*DATA_W +: DATA_W]), .rdata(wr_head[i]), .count(wr_cnt[i]));

    mparb_fifo #(.WIDTH(DATA_W), .DEPTH(DATA_DEPTH)) u_rd (
      .clk(clk), .rst_n(rst_s), .push(rd_push_v[i]), .pop(rd_pop[i]),
      .wdata(mem_rdata), .rdata(rd_data[i*DATA_W +: DATA_W]), .count(rd_cnt[i]));

    always_comb begin
      cmd_full[i]   = (cmd_cnt[i] == CCW'(CMD_DEPTH));
      cmd_empty[i]  = (cmd_cnt[i] == '0);
      wr_full[i]    = (wr_cnt[i] == DCW'(DATA_DEPTH));
      wr_empty_v[i] = (wr_cnt[i] == '0);
      rd_full_v[i]  = (rd_cnt[i] == DCW'(DATA_DEPTH));
      rd_empty[i]   = (rd_cnt[i] == '0);
      h_we          = head[i][CMDW-1];
      need          = 32'(head[i][LEN_W-1:0]) + 32'd1;
      if (cmd_empty[i])  elig[i] = 1'b0;
      else if (h_we)     elig[i] = (32'(wr_cnt[i]) >= need);
      else               elig[i] = ((32'(DATA_DEPTH) - 32'(rd_cnt[i])) >= need);
      cmd_pop_v[i] = take && grant[i];
      wr_pop_v[i]  = eng_pop && (eng_port == PW'(i));
      rd_push_v[i] = eng_push && (eng_port == PW'(i));
      ovf_d[i]     = ovf_q[i] | (cmd_push[i] & cmd_full[i]);
    end

    // R8
    rd_room_chk: assert property (@(posedge clk) disable iff (!rst_s)
      rd_push_v[i] |-> !rd_full_v[i]);
    // R7
    wr_avail_chk: assert property (@(posedge clk) disable iff (!rst_s)
      wr_pop_v[i] |-> !wr_empty_v[i]);
    // R2
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_s)
      (cmd_push[i] && cmd_full[i]) |=> cmd_ovf[i]);
    // R2
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s)
      cmd_ovf[i] |=> cmd_ovf[i]);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ovf_q <= '0;
    else        ovf_q <= ovf_d;
  end
  assign cmd_ovf = ovf_q;

  assign arb_req = eng_busy ? '0 : elig;
  assign take    = !eng_busy && (elig != '0);

  mparb_rr #(.N(NPORTS)) u_arb (
    .clk(clk), .rst_n(rst_s), .req(arb_req), .take(take),
    .grant(grant), .grant_idx(grant_idx));

  mparb_engine #(.AW(ADDR_W), .LW(LEN_W), .PW(PW)) u_eng (
    .clk(clk), .rst_n(rst_s), .start(take),
    .start_we(head[grant_idx][CMDW-1]),
    .start_addr(head[grant_idx][LEN_W +: ADDR_W]),
    .start_len(head[grant_idx][LEN_W-1:0]),
    .start_port(grant_idx),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .busy(eng_busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .port(eng_port), .wdata_pop(eng_pop), .rdata_push(eng_push));

  assign mem_wdata = wr_head[eng_port];

  // R5
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(cmd_pop_v) && (!eng_busy || (cmd_pop_v == '0)));
endmodule

// File: tb/mparb_top_tb_top.sv
`timescale 1ns/1ps
module mparb_top_tb_top;
  localparam int NP = 3, AW = 8, DW = 32, LW = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [NP-1:0]    cmd_push, cmd_write, cmd_full, cmd_empty, cmd_ovf;
  logic [NP*AW-1:0] cmd_addr;
  logic [NP*LW-1:0] cmd_len;
  logic [NP-1:0]    wr_push, wr_full, rd_pop, rd_empty;
  logic [NP*DW-1:0] wr_data, rd_data;
  logic             mem_req, mem_we, mem_ready, mem_rvalid;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_wdata, mem_rdata;

  logic          c_push [NP];
  logic          c_we   [NP];
  logic [AW-1:0] c_addr [NP];
  logic [LW-1:0] c_len  [NP];
  logic          w_push [NP];
  logic [DW-1:0] w_data [NP];
  logic          r_pop  [NP];

  for (genvar g = 0; g < NP; g++) begin : g_drv
    assign cmd_push[g]            = c_push[g];
    assign cmd_write[g]           = c_we[g];
    assign cmd_addr[g*AW +: AW]   = c_addr[g];
    assign cmd_len[g*LW +: LW]    = c_len[g];
    assign wr_push[g]             = w_push[g];
    assign wr_data[g*DW +: DW]    = w_data[g];
    assign rd_pop[g]              = r_pop[g];
  end

  mparb_top #(.NPORTS(NP), .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW),
              .CMD_DEPTH(4), .DATA_DEPTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_full(cmd_full),
    .cmd_empty(cmd_empty), .cmd_ovf(cmd_ovf), .wr_push(wr_push),
    .wr_data(wr_data), .wr_full(wr_full), .rd_pop(rd_pop), .rd_data(rd_data),
    .rd_empty(rd_empty), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  int checks = 0, fails = 0;
  logic [DW-1:0] mem    [256];
  logic [DW-1:0] shadow [256];
  logic          rnd_ready = 1'b0;
  logic          s1v, s2v;
  logic [DW-1:0] s1d, s2d;
  int            acc_cnt = 0;
  logic          log_en = 1'b0;
  logic [AW-1:0] alog [16];
  int            alog_n = 0;

  function automatic logic [DW-1:0] init_val(input int a);
    return (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0000;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: accepts on ready, read data returns two cycles later in order
  always @(negedge clk) mem_ready <= rnd_ready ? (($urandom % 4) != 0) : 1'b0;
  assign mem_rvalid = s2v;
  assign mem_rdata  = s2d;
  always @(posedge clk) begin
    if (!rst_n) begin
      s1v <= 1'b0; s2v <= 1'b0; s1d <= '0; s2d <= '0;
    end else begin
      s2v <= s1v; s2d <= s1d;
      s1v <= mem_req && mem_ready && !mem_we;
      s1d <= mem[mem_addr];
      if (mem_req && mem_ready) begin
        acc_cnt <= acc_cnt + 1;
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (log_en && alog_n < 16) begin
          alog[alog_n] <= mem_addr;
          alog_n <= alog_n + 1;
        end
      end
    end
  end

  task automatic push_cmd_raw(input int p, input bit we, input int addr, input int words);
    c_push[p] = 1'b1; c_we[p] = we; c_addr[p] = AW'(addr); c_len[p] = LW'(words - 1);
    @(negedge clk);
    c_push[p] = 1'b0;
  endtask

  task automatic push_cmd(input int p, input bit we, input int addr, input int words);
    while (cmd_full[p]) @(negedge clk);
    push_cmd_raw(p, we, addr, words);
  endtask

  task automatic push_wdata(input int p, input logic [DW-1:0] d);
    while (wr_full[p]) @(negedge clk);
    w_push[p] = 1'b1; w_data[p] = d;
    @(negedge clk);
    w_push[p] = 1'b0;
  endtask

  task automatic pop_word(input int p, output logic [DW-1:0] d);
    while (rd_empty[p]) @(negedge clk);
    d = rd_data[p*DW +: DW];
    r_pop[p] = 1'b1;
    @(negedge clk);
    r_pop[p] = 1'b0;
  endtask

  task automatic write_burst(input int p, input int addr, input int words);
    for (int k = 0; k < words; k++) begin
      logic [DW-1:0] d;
      d = $urandom;
      push_wdata(p, d);
      shadow[addr + k] = d;
    end
    push_cmd(p, 1'b1, addr, words);
  endtask

  task automatic read_check(input int p, input int addr, input int words, input string req);
    for (int k = 0; k < words; k++) begin
      logic [DW-1:0] d;
      pop_word(p, d);
      check(d === shadow[addr + k], req, d, shadow[addr + k]);
    end
  endtask

  task automatic port_run(input int p, input int n);
    for (int it = 0; it < n; it++) begin
      int words, addr;
      words = ($urandom % 16) + 1;
      addr  = p * 64 + ($urandom % 48);
      if ($urandom % 2 == 1) write_burst(p, addr, words);
      else begin
        push_cmd(p, 1'b0, addr, words);
        read_check(p, addr, words, "R3 random read data");
      end
    end
  endtask

  task automatic run_all();
    logic [DW-1:0] d;
    int base, n, bad;
    // R9 reset state
    @(negedge clk);
    check(cmd_empty == 3'b111, "R9 cmd_empty", cmd_empty, 3'b111);
    check(cmd_full == 3'b000 && cmd_ovf == 3'b000, "R9 full/ovf", {cmd_full, cmd_ovf}, 0);
    check(rd_empty == 3'b111 && mem_req == 1'b0, "R9 rd_empty/mem_req", {rd_empty, mem_req}, 4'b1110);

    // R6 rotation, R1 queueing during a burst, R5 hold under stall
    for (int p = 0; p < NP; p++) begin
      base = (p == 0) ? 8'h30 : (p == 1) ? 8'h70 : 8'hB0;
      for (int k = 0; k < 2; k++) begin
        d = $urandom; push_wdata(p, d); shadow[base + k] = d;
      end
    end
    log_en = 1'b1;
    push_cmd(1, 1'b1, 8'h70, 2);
    repeat (4) @(negedge clk);
    check(mem_req && mem_addr == 8'h70, "R5 stalled request address", mem_addr, 8'h70);
    push_cmd(2, 1'b1, 8'hB0, 2);
    push_cmd(0, 1'b1, 8'h30, 2);
    repeat (3) @(negedge clk);
    check(cmd_empty[0] == 1'b0 && cmd_empty[2] == 1'b0, "R1 queued while busy", cmd_empty, 3'b010);
    check(mem_req && mem_addr == 8'h70 && mem_we, "R5 request held", mem_addr, 8'h70);
    rnd_ready = 1'b1;
    repeat (40) @(negedge clk);
    log_en = 1'b0;
    check(alog_n == 6, "R6 grant count", alog_n, 6);
    check(alog[0] == 8'h70 && alog[1] == 8'h71, "R6 first port 1", alog[0], 8'h70);
    check(alog[2] == 8'hB0 && alog[3] == 8'hB1, "R6 then port 2", alog[2], 8'hB0);
    check(alog[4] == 8'h30 && alog[5] == 8'h31, "R6 wrap to port 0", alog[4], 8'h30);
    check(mem[8'hB1] == shadow[8'hB1], "R4 directed write", mem[8'hB1], shadow[8'hB1]);

    // R7 write held until full payload queued
    n = acc_cnt;
    for (int k = 0; k < 3; k++) begin
      d = $urandom; push_wdata(1, d); shadow[8'h60 + k] = d;
    end
    push_cmd(1, 1'b1, 8'h60, 4);
    repeat (20) @(negedge clk);
    check(acc_cnt == n && cmd_empty[1] == 1'b0, "R7 write held", acc_cnt - n, 0);
    d = $urandom; push_wdata(1, d); shadow[8'h63] = d;
    repeat (30) @(negedge clk);
    check(acc_cnt == n + 4 && cmd_empty[1], "R7 write issued", acc_cnt - n, 4);
    check(mem[8'h63] == shadow[8'h63], "R4 last word of write", mem[8'h63], shadow[8'h63]);

    // R8 read held while no room
    push_cmd(2, 1'b0, 8'h80, 16);
    repeat (60) @(negedge clk);
    push_cmd(2, 1'b0, 8'h90, 1);
    repeat (30) @(negedge clk);
    check(cmd_empty[2] == 1'b0, "R8 read held without room", cmd_empty[2], 0);
    read_check(2, 8'h80, 16, "R3 full burst data");
    read_check(2, 8'h90, 1, "R3 single word read");
    check(cmd_empty[2] == 1'b1, "R8 read issued after room", cmd_empty[2], 1);

    // R2 overflow, R10 maximum burst length
    rnd_ready = 1'b0;
    repeat (4) @(negedge clk);
    push_cmd(0, 1'b0, 8'h00, 16);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) push_cmd(0, 1'b0, 8'h00, 16);
    check(cmd_full[0] == 1'b1 && cmd_ovf == 3'b000, "R1 queue full, no ovf yet", {cmd_full, cmd_ovf}, 6'b001000);
    push_cmd_raw(0, 1'b0, 8'h00, 16);
    check(cmd_ovf == 3'b001, "R2 overflow flag", cmd_ovf, 3'b001);
    rnd_ready = 1'b1;
    for (int b = 0; b < 5; b++) read_check(0, 8'h00, 16, "R10 16-word burst data");
    repeat (60) @(negedge clk);
    check(rd_empty[0] && cmd_empty[0], "R2 dropped push not executed", {rd_empty[0], cmd_empty[0]}, 2'b11);
    check(cmd_ovf == 3'b001, "R2 overflow sticky", cmd_ovf, 3'b001);

    // random traffic on all ports at once
    fork
      port_run(0, 25);
      port_run(1, 25);
      port_run(2, 25);
    join
    repeat (80) @(negedge clk);
    bad = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== shadow[a]) bad++;
    check(bad == 0, "R4 memory image after random writes", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < 256; a++) begin
      mem[a] = init_val(a);
      shadow[a] = init_val(a);
    end
    for (int p = 0; p < NP; p++) begin
      c_push[p] = 1'b0; c_we[p] = 1'b0; c_addr[p] = '0; c_len[p] = '0;
      w_push[p] = 1'b0; w_data[p] = '0; r_pop[p] = 1'b0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule